// File: doc/BRIEF.md
# System Tick Timer

A 24-bit down-counting tick timer for periodic interrupts. Software programs a reload value and sets three gate bits in a control word. The counter then steps down once per clock from the reload value to zero, reloads, and on each wrap sets a sticky flag and, if enabled, emits a one-cycle interrupt request. The tick period is reload+1 clock cycles. A 1 ms tick at 64 MHz therefore needs a programmed reload of 63999.

The block keeps a 32-bit elapsed-tick count that advances on every interrupt pulse. Software can read it as a running count of milliseconds when the tick is set to 1 ms. All state is reached through a small word-addressed register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, reload, current value and elapsed count all read 0, and `tickIrq` is low.
- R2: The counter changes only while control bit 0 (count enable) and control bit 2 (core-clock source select) are both 1. Otherwise the current value (word address 2) holds.
- R3: While counting, a current value of 0 loads the reload value and any other value decrements by one. The step from 1 to 0 is a wrap, so wraps are reload+1 cycles apart.
- R4: A wrap sets the count flag at control bit 16. It raises `tickIrq` for exactly one cycle only when control bit 1 (interrupt enable) is 1. With bit 1 clear, `tickIrq` stays low.
- R5: A read of the control word (word address 0) returns the flag and clears it, so a second read returns bit 16 as 0.
- R6: A write of any data to the current value (word address 2) sets the counter to 0 and clears the count flag.
- R7: The reload register (word address 1) keeps only write bits 23:0 and reads back zero above them. A reload of 0 keeps the counter at 0 with no wrap and no interrupt.
- R8: The elapsed count (word address 3) increases by one for every `tickIrq` pulse, and writes to it are ignored.
- R9: Control bits other than 0, 1, 2 and 16 read as 0 and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count source |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address: 0 control, 1 reload, 2 current, 3 elapsed |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr` |
| tickIrq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The assertions assume that a write to the current value is the only thing that moves the counter while counting is gated off. They also assume the irq pulse cannot repeat on consecutive cycles, which requires the counter to pass through 0 between wraps. The stimulus changes reload and control only through single-cycle bus accesses, with the bus idle in between. The stimulus programs a reload of 0 only together with a current-value clear, so the quiet-state property has a defined starting point.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int FLAG_BIT  = 16;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_RLD   = 1;
  localparam int ADR_CUR   = 2;
  localparam int ADR_ELAP  = 3;

  typedef struct packed {
    logic wrCtrl;
    logic wrReload;
    logic wrCurrent;
    logic rdCtrl;
  } strobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int ELAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        wrBits,
  input  logic              wrapEvt,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [ELAP_W-1:0] elapsedVal,
  output strobe_t           strobes,
  output logic              running,
  output logic              irqEn,
  output logic              flagVal,
  output logic [DATA_W-1:0] busRdata
);
  logic [2:0] ctrlQ;

  always_comb begin
    strobes.wrCtrl    = busSel && busWr  && (int'(busAddr) == ADR_CTRL);
    strobes.wrReload  = busSel && busWr  && (int'(busAddr) == ADR_RLD);
    strobes.wrCurrent = busSel && busWr  && (int'(busAddr) == ADR_CUR);
    strobes.rdCtrl    = busSel && !busWr && (int'(busAddr) == ADR_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ   <= '0;
      flagVal <= 1'b0;
    end else begin
      if (strobes.wrCtrl) ctrlQ <= wrBits;
      if (wrapEvt) flagVal <= 1'b1;
      else if (strobes.rdCtrl || strobes.wrCurrent) flagVal <= 1'b0;
    end
  end

  assign running = ctrlQ[0] && ctrlQ[2];
  assign irqEn   = ctrlQ[1];

  always_comb begin
    busRdata = '0;
    case (int'(busAddr))
      ADR_CTRL: begin
        busRdata[2:0]      = ctrlQ;
        busRdata[FLAG_BIT] = flagVal;
      end
      ADR_RLD:  busRdata[CNT_W-1:0]  = reloadVal;
      ADR_CUR:  busRdata[CNT_W-1:0]  = cntVal;
      ADR_ELAP: busRdata[ELAP_W-1:0] = elapsedVal;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_dp.sv
module tick_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ELAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              running,
  input  logic              irqEn,
  output logic              wrapEvt,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  cntVal,
  output logic [ELAP_W-1:0] elapsedVal,
  output logic              tickIrq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign wrapEvt = running && (cntVal == ONE) && !strobes.wrCurrent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloadVal  <= '0;
      cntVal     <= '0;
      elapsedVal <= '0;
      tickIrq    <= 1'b0;
    end else begin
      if (strobes.wrReload) reloadVal <= wrData;
      if (strobes.wrCurrent) cntVal <= '0;
      else if (running) cntVal <= (cntVal == '0) ? reloadVal : cntVal - ONE;
      tickIrq <= wrapEvt && irqEn;
      if (wrapEvt && irqEn) elapsedVal <= elapsedVal + ELAP_W'(1);
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int ELAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickIrq
);
  strobe_t           strobes;
  logic              running, irqEn, flagVal, wrapEvt;
  logic [CNT_W-1:0]  reloadVal, cntVal;
  logic [ELAP_W-1:0] elapsedVal;

  tick_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ELAP_W(ELAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .wrBits(busWdata[2:0]), .wrapEvt(wrapEvt), .reloadVal(reloadVal), .cntVal(cntVal),
    .elapsedVal(elapsedVal), .strobes(strobes), .running(running), .irqEn(irqEn),
    .flagVal(flagVal), .busRdata(busRdata)
  );

  tick_dp #(.CNT_W(CNT_W), .ELAP_W(ELAP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(busWdata[CNT_W-1:0]),
    .running(running), .irqEn(irqEn), .wrapEvt(wrapEvt), .reloadVal(reloadVal),
    .cntVal(cntVal), .elapsedVal(elapsedVal), .tickIrq(tickIrq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickIrq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             running,
  input logic             flagVal,
  input logic             wrCurrent
);
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |=> !tickIrq);
  a_r4_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> flagVal);
  a_r3_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> (cntVal == '0));
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wrCurrent) |=> $stable(cntVal));
  a_r6_current_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wrCurrent |=> (cntVal == '0 && !flagVal));
  a_r7_zero_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reloadVal == '0 && cntVal == '0) |=> !tickIrq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tickIrq(tickIrq), .cntVal(cntVal),
  .reloadVal(reloadVal), .running(running), .flagVal(flagVal),
  .wrCurrent(strobes.wrCurrent)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIrq;
  int total = 0, bad = 0, irqCount = 0;

  always #10 clk = ~clk;

  tick_timer u_dut (.clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .tickIrq(tickIrq));

  always @(negedge clk) if (rst_n && tickIrq) irqCount++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic finishUp;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic measureInterval(output int n);
    int guard = 0;
    while (!tickIrq && guard < 70000) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!tickIrq && n < 70000);
  endtask

  task automatic test_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset register", d, 32'h0);
    end
    chk("R1 irq low", {31'b0, tickIrq}, 32'h0);
  endtask

  task automatic test_sequence;
    logic [31:0] d;
    int e = 0, startIrq;
    wr(2'd1, 32'd5); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
    startIrq = irqCount;
    busSel = 1'b1; busWr = 1'b0; busAddr = 2'd2;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      e = (e == 0) ? 5 : e - 1;
      #1 chk("R3 count value", busRdata, 32'(e));
    end
    busSel = 1'b0;
    wr(2'd0, 32'h0);
    chk("R4 no irq when disabled", 32'(irqCount - startIrq), 32'h0);
    rd(2'd0, d); chk("R5 flag set after wrap", d, 32'h0001_0000);
    rd(2'd0, d); chk("R5 flag cleared by read", d, 32'h0);
  endtask

  task automatic test_interval;
    logic [31:0] d;
    int n;
    wr(2'd1, 32'd6); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    for (int i = 0; i < 3; i++) begin
      measureInterval(n); chk("R3 irq interval reload 6", 32'(n), 32'd7);
    end
    @(negedge clk);
    chk("R4 irq one cycle", {31'b0, tickIrq}, 32'h0);
    wr(2'd0, 32'h0);
    rd(2'd3, d); chk("R8 elapsed equals irq count", d, 32'(irqCount));
    wr(2'd3, 32'h1234);
    rd(2'd3, d); chk("R8 elapsed write ignored", d, 32'(irqCount));
  endtask

  task automatic test_gating;
    logic [31:0] d;
    wr(2'd1, 32'd4); wr(2'd2, 32'h0);
    wr(2'd0, 32'h5); wr(2'd0, 32'h1);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R2 hold with source bit clear", d, 32'd4);
    wr(2'd0, 32'h4);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R2 hold with enable bit clear", d, 32'd4);
  endtask

  task automatic test_current_write;
    logic [31:0] d;
    wr(2'd1, 32'd2); wr(2'd0, 32'h5);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0012_3456);
    rd(2'd2, d); chk("R6 current cleared by write", d, 32'h0);
    rd(2'd0, d); chk("R6 flag cleared by current write", d, 32'h0);
  endtask

  task automatic test_reload;
    logic [31:0] d;
    int startIrq;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R7 reload width", d, 32'h00FF_FFFF);
    wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    startIrq = irqCount;
    wr(2'd0, 32'h7);
    repeat (40) @(negedge clk);
    chk("R7 zero reload no irq", 32'(irqCount - startIrq), 32'h0);
    rd(2'd2, d); chk("R7 zero reload stays 0", d, 32'h0);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R7 zero reload no flag", d, 32'h0);
  endtask

  task automatic test_ctrl_bits;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R9 reserved control bits", d, 32'h7);
    wr(2'd0, 32'h0);
  endtask

  task automatic test_ms_tick;
    logic [31:0] d;
    int n;
    wr(2'd1, 32'd63999); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
    measureInterval(n); chk("R3 1 ms interval at 64 MHz", 32'(n), 32'd64000);
    wr(2'd0, 32'h0);
    rd(2'd3, d); chk("R8 elapsed after ms ticks", d, 32'(irqCount));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_sequence();
    test_interval();
    test_gating();
    test_current_write();
    test_reload();
    test_ctrl_bits();
    test_ms_tick();
    finishUp();
  end
endmodule